// File: doc/BRIEF.md
# Bridge Type-1 Configuration Register File

This block keeps the bridge-specific registers of a type-1 configuration header: the command word, the three bus numbers and the secondary latency timer, the I/O, memory and prefetchable base/limit windows with their upper halves, and the bridge control word. A requester reaches it through a dword-addressed configuration port with one enable per byte lane. Reads return a fixed identity (vendor, device, revision, class code and header type), constant status capabilities and the live register contents.

Writes have side effects. Any write whose enabled bytes touch a register that shapes the forwarding windows raises a one-cycle remap strobe, so the address decoders downstream can reload their windows. Setting the bus-reset bit of bridge control from 0 to 1 fires a one-cycle secondary reset pulse. A separate forwarding-disable input loads every base above its limit, which shuts all windows in one cycle.

Top module: `bcfg_regs`

## Requirements
- R1: After reset the command word, all bus numbers, the secondary latency timer, every address bit of the base and limit registers, all upper-half registers and bridge control read zero.
- R2: Dword 0 reads {DEVICE_ID, VENDOR_ID}; dword 2 reads class 0x060400 in bits 31:8 and REV_ID in bits 7:0; dword 3 reads {MULTI_FUNC, 7'h01} in bits 23:16 and zero elsewhere.
- R3: Bits 31:16 of dword 1 and of dword 7 always read 0x00A0 (66 MHz and fast back-to-back capable) and ignore writes.
- R4: A write changes only the byte lanes whose enable is set; a write with no enables changes nothing.
- R5: The low nibble of each base/limit register is read-only: 0x1 for the I/O pair (dword 7 bytes 0 and 1) and the prefetchable pair (dword 9 bits 3:0 and 19:16), 0x0 for the memory pair; neither reset nor the disable command alters it.
- R6: A write with an enabled byte at offsets 0x04-0x05, 0x1C-0x1D, 0x20-0x33 or 0x3E-0x3F raises remap_pulse in the cycle after the write; other writes leave it low.
- R7: sec_reset_pulse rises in the cycle after a write that takes bridge-control bit 6 (dword 15 bit 22) from 0 to 1; a write that keeps it at 1 or clears it does not fire it.
- R8: disable_fwd sets every address bit of each base register, clears every address bit of each limit register, zeroes both prefetchable upper registers, leaves the I/O upper registers unchanged, drops a write in the same cycle and raises remap_pulse in the next cycle.
- R9: cfg_rdata takes the contents of the addressed dword, as they were before any write in the same cycle, one cycle after cfg_rd; unimplemented dwords read zero; without cfg_rd it holds.
- R10: remap_pulse and sec_reset_pulse last one cycle per cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Write request |
| cfg_rd | input | 1 | Read request |
| cfg_addr | input | ADDR_W | Dword index into the header |
| cfg_be | input | 4 | Byte-lane enables for writes |
| cfg_wdata | input | 32 | Write data |
| disable_fwd | input | 1 | Close all forwarding windows |
| cfg_rdata | output | 32 | Read data, one cycle after cfg_rd |
| remap_pulse | output | 1 | Windows changed, reload decoders |
| sec_reset_pulse | output | 1 | Secondary bus reset request |

## Verification
Every result of this block is due exactly one clock after the request that causes it: read data, the remap strobe and the secondary reset pulse are all registered once. The bench drives each request on a falling edge, lets one rising edge pass and samples on the next falling edge, then drops the request and samples again a cycle later to confirm both pulses have ended. Write effects are checked by a separate read one cycle after the write, and the read-during-write case checks that the old contents come back.

// File: rtl/bcfg_pkg.sv
package bcfg_pkg;
    localparam int DATA_W = 32;
    localparam int LANES  = DATA_W / 8;
    localparam int LSB_W  = $clog2(LANES);

    localparam logic [15:0] STAT_CAPS = 16'h00A0;
    localparam logic [23:0] CLASS_P2P = 24'h060400;
    localparam logic [6:0]  HDR_KIND1 = 7'h01;
    localparam logic [3:0]  IO_KIND   = 4'h1;
    localparam logic [3:0]  MEM_KIND  = 4'h0;
    localparam logic [3:0]  PF_KIND   = 4'h1;
    localparam int          BUSRST_BIT = 6;

    localparam int DW_ID    = 0;
    localparam int DW_CMD   = 1;
    localparam int DW_CLASS = 2;
    localparam int DW_HDR   = 3;
    localparam int DW_BUS   = 6;
    localparam int DW_IO    = 7;
    localparam int DW_MEM   = 8;
    localparam int DW_PF    = 9;
    localparam int DW_PFBU  = 10;
    localparam int DW_PFLU  = 11;
    localparam int DW_IOU   = 12;
    localparam int DW_BCTL  = 15;

    typedef struct packed {
        logic [15:0] cmd;
        logic [7:0]  pri_bus;
        logic [7:0]  sec_bus;
        logic [7:0]  sub_bus;
        logic [7:0]  lat;
        logic [3:0]  io_base_a;
        logic [3:0]  io_lim_a;
        logic [11:0] mem_base_a;
        logic [11:0] mem_lim_a;
        logic [11:0] pf_base_a;
        logic [11:0] pf_lim_a;
        logic [31:0] pf_base_up;
        logic [31:0] pf_lim_up;
        logic [15:0] io_base_up;
        logic [15:0] io_lim_up;
        logic [15:0] bctl;
        logic        remap;
        logic        sreset;
        logic [31:0] rdata;
    } regs_t;

    // Byte offsets whose modification reshapes a forwarding window.
    function automatic logic window_byte(input int unsigned off);
        return (off >= 4  && off <= 5)  ||
               (off >= 28 && off <= 29) ||
               (off >= 32 && off <= 51) ||
               (off >= 62 && off <= 63);
    endfunction
endpackage

// File: rtl/bcfg_win_hit.sv
module bcfg_win_hit
    import bcfg_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  be,
    output logic              hit
);
    logic [LANES-1:0] lane_hit;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam logic [LSB_W-1:0] LANE_IDX = LSB_W'(g);
        logic [ADDR_W+LSB_W-1:0] off;
        assign off         = {addr, LANE_IDX};
        assign lane_hit[g] = be[g] && window_byte(int'(off));
    end

    assign hit = |lane_hit;
endmodule

// File: rtl/bcfg_lane_merge.sv
module bcfg_lane_merge
    import bcfg_pkg::*;
(
    input  logic [DATA_W-1:0] old_word,
    input  logic [DATA_W-1:0] new_word,
    input  logic [LANES-1:0]  be,
    output logic [DATA_W-1:0] merged
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign merged[g*8 +: 8] = be[g] ? new_word[g*8 +: 8] : old_word[g*8 +: 8];
    end
endmodule

// File: rtl/bcfg_regs.sv
module bcfg_regs
    import bcfg_pkg::*;
#(
    parameter int          ADDR_W     = 6,
    parameter logic [15:0] VENDOR_ID  = 16'hABCD,
    parameter logic [15:0] DEVICE_ID  = 16'h1234,
    parameter logic [7:0]  REV_ID     = 8'h02,
    parameter logic        MULTI_FUNC = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              cfg_rd,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [3:0]        cfg_be,
    input  logic [31:0]       cfg_wdata,
    input  logic              disable_fwd,
    output logic [31:0]       cfg_rdata,
    output logic              remap_pulse,
    output logic              sec_reset_pulse
);
    regs_t st_q, st_d;
    logic [31:0] img_cur, merged;
    logic        win_hit;

    function automatic logic [31:0] image(input regs_t r, input logic [ADDR_W-1:0] a);
        case (a)
            ADDR_W'(DW_ID):    image = {DEVICE_ID, VENDOR_ID};
            ADDR_W'(DW_CMD):   image = {STAT_CAPS, r.cmd};
            ADDR_W'(DW_CLASS): image = {CLASS_P2P, REV_ID};
            ADDR_W'(DW_HDR):   image = {8'h00, MULTI_FUNC, HDR_KIND1, 16'h0000};
            ADDR_W'(DW_BUS):   image = {r.lat, r.sub_bus, r.sec_bus, r.pri_bus};
            ADDR_W'(DW_IO):    image = {STAT_CAPS, r.io_lim_a, IO_KIND, r.io_base_a, IO_KIND};
            ADDR_W'(DW_MEM):   image = {r.mem_lim_a, MEM_KIND, r.mem_base_a, MEM_KIND};
            ADDR_W'(DW_PF):    image = {r.pf_lim_a, PF_KIND, r.pf_base_a, PF_KIND};
            ADDR_W'(DW_PFBU):  image = r.pf_base_up;
            ADDR_W'(DW_PFLU):  image = r.pf_lim_up;
            ADDR_W'(DW_IOU):   image = {r.io_lim_up, r.io_base_up};
            ADDR_W'(DW_BCTL):  image = {r.bctl, 16'h0000};
            default:           image = 32'h0;
        endcase
    endfunction

    assign img_cur = image(st_q, cfg_addr);

    bcfg_lane_merge u_merge (
        .old_word (img_cur),
        .new_word (cfg_wdata),
        .be       (cfg_be),
        .merged   (merged)
    );

    bcfg_win_hit #(.ADDR_W(ADDR_W)) u_hit (
        .addr (cfg_addr),
        .be   (cfg_be),
        .hit  (win_hit)
    );

    always_comb begin
        st_d        = st_q;
        st_d.remap  = 1'b0;
        st_d.sreset = 1'b0;
        if (cfg_rd) st_d.rdata = img_cur;
        if (disable_fwd) begin
            st_d.io_base_a  = '1;
            st_d.io_lim_a   = '0;
            st_d.mem_base_a = '1;
            st_d.mem_lim_a  = '0;
            st_d.pf_base_a  = '1;
            st_d.pf_lim_a   = '0;
            st_d.pf_base_up = '0;
            st_d.pf_lim_up  = '0;
            st_d.remap      = 1'b1;
        end else if (cfg_wr) begin
            st_d.remap = win_hit;
            case (cfg_addr)
                ADDR_W'(DW_CMD): st_d.cmd = merged[15:0];
                ADDR_W'(DW_BUS): {st_d.lat, st_d.sub_bus, st_d.sec_bus, st_d.pri_bus} = merged;
                ADDR_W'(DW_IO): begin
                    st_d.io_base_a = merged[7:4];
                    st_d.io_lim_a  = merged[15:12];
                end
                ADDR_W'(DW_MEM): begin
                    st_d.mem_base_a = merged[15:4];
                    st_d.mem_lim_a  = merged[31:20];
                end
                ADDR_W'(DW_PF): begin
                    st_d.pf_base_a = merged[15:4];
                    st_d.pf_lim_a  = merged[31:20];
                end
                ADDR_W'(DW_PFBU): st_d.pf_base_up = merged;
                ADDR_W'(DW_PFLU): st_d.pf_lim_up  = merged;
                ADDR_W'(DW_IOU):  {st_d.io_lim_up, st_d.io_base_up} = merged;
                ADDR_W'(DW_BCTL): begin
                    st_d.bctl   = merged[31:16];
                    st_d.sreset = !st_q.bctl[BUSRST_BIT] && merged[16+BUSRST_BIT];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg_rdata       = st_q.rdata;
    assign remap_pulse     = st_q.remap;
    assign sec_reset_pulse = st_q.sreset;

    // R6: a window-touching write is followed by the strobe
    a_r6_remap_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !disable_fwd && win_hit) |=> remap_pulse);
    // R6: no request, no strobe
    a_r6_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_wr && !disable_fwd) |=> !remap_pulse);
    // R10: the secondary reset never lasts two cycles
    a_r10_sreset_width: assert property (@(posedge clk) disable iff (!rst_n)
        sec_reset_pulse |=> !sec_reset_pulse);
    // R7: the secondary reset only follows a write
    a_r7_sreset_cause: assert property (@(posedge clk) disable iff (!rst_n)
        sec_reset_pulse |-> ($past(cfg_wr) && !$past(disable_fwd)));
    // R8: disable leaves every base above its limit
    a_r8_closed: assert property (@(posedge clk) disable iff (!rst_n)
        disable_fwd |=> (st_q.mem_base_a == '1 && st_q.mem_lim_a == '0 &&
                         st_q.pf_base_a == '1 && st_q.pf_lim_a == '0 &&
                         st_q.io_base_a == '1 && st_q.io_lim_a == '0 &&
                         st_q.pf_base_up == '0 && st_q.pf_lim_up == '0 && remap_pulse));
endmodule

// File: tb/sim_bcfg_regs.sv
`timescale 1ns/1ps
module sim_bcfg_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0, cfg_rd = 1'b0, disable_fwd = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        remap_pulse, sec_reset_pulse;
    int checks = 0, errors = 0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    bcfg_regs u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
        .cfg_addr(cfg_addr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
        .disable_fwd(disable_fwd), .cfg_rdata(cfg_rdata),
        .remap_pulse(remap_pulse), .sec_reset_pulse(sec_reset_pulse)
    );

    typedef struct packed {
        logic [5:0]  a;
        logic [3:0]  be;
        logic [31:0] wd;
        logic [31:0] exp;
        logic        rm;
        logic        sr;
    } vec_t;

    localparam vec_t VEC [0:16] = '{
        '{6'd6,  4'hF, 32'h4005_0100, 32'h4005_0100, 1'b0, 1'b0},
        '{6'd7,  4'h3, 32'hFFFF_F5A3, 32'h00A0_F1A1, 1'b1, 1'b0},
        '{6'd7,  4'hC, 32'h1234_5678, 32'h00A0_F1A1, 1'b0, 1'b0},
        '{6'd8,  4'hF, 32'hABCD_1237, 32'hABC0_1230, 1'b1, 1'b0},
        '{6'd9,  4'h1, 32'hFFFF_FFFF, 32'h0001_00F1, 1'b1, 1'b0},
        '{6'd10, 4'hF, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 1'b1, 1'b0},
        '{6'd12, 4'h6, 32'h1122_3344, 32'h0022_3300, 1'b1, 1'b0},
        '{6'd1,  4'h2, 32'h0000_0500, 32'h00A0_0500, 1'b1, 1'b0},
        '{6'd1,  4'hC, 32'hFFFF_FFFF, 32'h00A0_0500, 1'b0, 1'b0},
        '{6'd15, 4'h4, 32'h0040_0000, 32'h0040_0000, 1'b1, 1'b1},
        '{6'd15, 4'h4, 32'h0041_0000, 32'h0041_0000, 1'b1, 1'b0},
        '{6'd15, 4'h8, 32'h0200_0000, 32'h0241_0000, 1'b1, 1'b0},
        '{6'd15, 4'h1, 32'hFFFF_FFFF, 32'h0241_0000, 1'b0, 1'b0},
        '{6'd15, 4'hC, 32'h0000_0000, 32'h0000_0000, 1'b1, 1'b0},
        '{6'd15, 4'hC, 32'h0040_0000, 32'h0040_0000, 1'b1, 1'b1},
        '{6'd11, 4'h0, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0, 1'b0},
        '{6'd20, 4'hF, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [5:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        cfg_rd = 1'b1; cfg_addr = a;
        @(negedge clk);
        cfg_rd = 1'b0;
        chk(req, cfg_rdata, exp);
    endtask

    // Write, then sample both pulses one cycle later and again a cycle after that.
    task automatic wr(input logic [5:0] a, input logic [3:0] be, input logic [31:0] d,
                      input logic rm, input logic sr, input string req);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_be = be; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_be = '0;
        chk({req, " remap"}, 32'(remap_pulse), 32'(rm));
        chk({req, " sreset"}, 32'(sec_reset_pulse), 32'(sr));
        @(negedge clk);
        chk("R10 remap width", 32'(remap_pulse), 32'h0);
        chk("R10 sreset width", 32'(sec_reset_pulse), 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1, R2, R3, R5 reset image
        rd(6'd0,  32'h1234_ABCD, "R2 id");
        rd(6'd2,  32'h0604_0002, "R2 class");
        rd(6'd3,  32'h0001_0000, "R2 header");
        rd(6'd1,  32'h00A0_0000, "R1 R3 cmd/status");
        rd(6'd6,  32'h0000_0000, "R1 bus numbers");
        rd(6'd7,  32'h00A0_0101, "R1 R5 io");
        rd(6'd8,  32'h0000_0000, "R1 mem");
        rd(6'd9,  32'h0001_0001, "R1 R5 pref");
        rd(6'd10, 32'h0000_0000, "R1 pref base up");
        rd(6'd12, 32'h0000_0000, "R1 io up");
        rd(6'd15, 32'h0000_0000, "R1 bctl");
        // R9 hold without cfg_rd
        @(negedge clk);
        chk("R9 hold", cfg_rdata, 32'h0);

        // Table: R4 R5 R6 R7 via vectors
        for (int i = 0; i < 17; i++) begin
            wr(VEC[i].a, VEC[i].be, VEC[i].wd, VEC[i].rm, VEC[i].sr, $sformatf("R6 R7 vec%0d", i));
            rd(VEC[i].a, VEC[i].exp, $sformatf("R4 R5 vec%0d", i));
        end

        // R9 read during write returns old content
        @(negedge clk);
        cfg_rd = 1'b1; cfg_wr = 1'b1; cfg_addr = 6'd6; cfg_be = 4'hF; cfg_wdata = 32'h0;
        @(negedge clk);
        cfg_rd = 1'b0; cfg_wr = 1'b0; cfg_be = '0;
        chk("R9 old data", cfg_rdata, 32'h4005_0100);
        rd(6'd6, 32'h0, "R9 new data");

        // R8 disable with a concurrent write that must be dropped
        @(negedge clk);
        disable_fwd = 1'b1; cfg_wr = 1'b1; cfg_addr = 6'd6; cfg_be = 4'hF; cfg_wdata = 32'h1111_1111;
        @(negedge clk);
        disable_fwd = 1'b0; cfg_wr = 1'b0; cfg_be = '0;
        chk("R8 remap", 32'(remap_pulse), 32'h1);
        chk("R8 no sreset", 32'(sec_reset_pulse), 32'h0);
        @(negedge clk);
        chk("R10 remap after disable", 32'(remap_pulse), 32'h0);
        rd(6'd6,  32'h0000_0000, "R8 write dropped");
        rd(6'd7,  32'h00A0_01F1, "R8 io");
        rd(6'd8,  32'h0000_FFF0, "R8 mem");
        rd(6'd9,  32'h0001_FFF1, "R8 pref");
        rd(6'd10, 32'h0000_0000, "R8 pref base up");
        rd(6'd11, 32'h0000_0000, "R8 pref lim up");
        rd(6'd12, 32'h0022_3300, "R8 io up kept");

        // R1 reset again after activity
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd(6'd15, 32'h0000_0000, "R1 bctl cleared");
        rd(6'd7,  32'h00A0_0101, "R1 io cleared");
        rd(6'd1,  32'h00A0_0000, "R1 cmd cleared");
        rd(6'd12, 32'h0000_0000, "R1 io up cleared");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog act=running exp=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule